// File: doc/BRIEF.md
# Two-Channel Fixed-Priority DMA Engine

This block moves data on behalf of the CPU through one bus master port. It has two channels. Each channel is loaded in one cycle from its configuration inputs by a start pulse. The configuration gives a source address, a destination address, a 16-bit unit count, a unit width, a request source, a cycle-steal or burst choice, and a single- or dual-address choice. Before any bus access, the engine asks for the bus on `bus_req` and waits for `bus_gnt`.

In dual-address mode a unit is a read from the source address into a holding register, followed by a write of that data to the destination. In single-address mode a unit is one read at the source address. A device-side acknowledge strobe marks the cycle in which that read completes, so the device can take or supply the data directly. After every unit the count drops by one and both addresses advance by the unit width in bytes. When the count reaches zero the channel stops and raises a sticky done flag. A new start clears the flag.

In cycle-steal mode the bus is handed back after each unit and the channels are arbitrated again. In burst mode the channel keeps the bus until its count runs out. Channel 0 always has priority at arbitration.

Top module: `dma2_ctrl`

## Requirements
- R1: When both channels have a pending request at the moment the grant is taken, channel 0 is served first.
- R2: A start with a count of zero sets that channel's done flag on the next cycle and performs no bus access. A start with a nonzero count clears done and arms the channel.
- R3: After each completed unit, the addresses the channel uses next are advanced by 1, 2 or 4 bytes, for width codes 0, 1 and 2 respectively. The unit count decrements by one.
- R4: When the unit that brings the count to zero completes, done goes high on the next cycle. That channel then makes no further bus access.
- R5: In cycle-steal mode, `bus_req` is low for at least one cycle after each unit. The channel is re-selected by priority, so a channel 0 request started mid-run is served before channel 1 finishes.
- R6: In burst mode the channel keeps `bus_req` high and goes on with its next unit immediately. It is not preempted by a channel 0 request that arrives during the burst.
- R7: In dual-address mode (select 0), each unit reads the source address and then writes the read data to the destination address. A write never begins unless a completed read directly precedes it.
- R8: In single-address mode (select 1), each unit is exactly one read at the source address. During the cycle that read completes, `ack` for the channel is high. No write is issued.
- R9: The request source code selects what arms a channel's request: 0 is `ext_req`, 1 is always (auto-request), 2 is `periph_req`. While the selected request is low, the channel raises no `bus_req`.
- R10: A bus access starts only one cycle after `bus_gnt` was seen high. `m_ready` low stretches an access without losing or corrupting data.
- R11: After reset `bus_req`, `m_valid`, `ack` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | NCH | Per-channel load-and-arm pulse |
| cfg_src | input | NCH x AW | Source start address per channel |
| cfg_dst | input | NCH x AW | Destination start address per channel |
| cfg_count | input | NCH x CW | Number of units per channel |
| cfg_size | input | NCH x 2 | Unit width code: 0 = 8, 1 = 16, 2 = 32 bits |
| cfg_reqsel | input | NCH x 2 | Request source: 0 = pin, 1 = auto, 2 = peripheral |
| cfg_burst | input | NCH | 1 = burst, 0 = cycle-steal |
| cfg_single | input | NCH | 1 = single-address, 0 = dual-address |
| ext_req | input | NCH | External request pin per channel |
| periph_req | input | NCH | On-chip peripheral request per channel |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| m_valid | output | 1 | Access in progress |
| m_write | output | 1 | 1 = write, 0 = read |
| m_addr | output | AW | Access address |
| m_size | output | 2 | Access width code |
| m_wdata | output | DW | Write data (holding register) |
| m_ready | input | 1 | Access completes in this cycle |
| m_rdata | input | DW | Read data, valid with m_ready on a read |
| ack | output | NCH | Single-address acknowledge strobe |
| done | output | NCH | Sticky channel-complete flag |

## Verification
A wrong address or count register shows at the ports on the very next unit. It appears as a write landing at the wrong destination or carrying the wrong data, or as a missing or extra unit by the time done rises. A wrong state-machine state shows within one cycle on `bus_req`, `m_valid` or `m_write`. Examples are a write with no read before it, a bus request that stays high between cycle-steal units, or a burst that lets go of the bus. Priority faults show as the order of destination addresses in the write stream when both channels compete.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } unit_size_e;

    typedef enum logic [1:0] {
        RQ_PIN    = 2'd0,
        RQ_AUTO   = 2'd1,
        RQ_PERIPH = 2'd2
    } req_src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE
    } xfer_state_e;

    typedef struct packed {
        logic       burst;
        logic       single;
        logic [1:0] size;
    } chan_mode_t;

    function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
    import dma2_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_count,
    input  logic [1:0]    cfg_size,
    input  logic [1:0]    cfg_reqsel,
    input  logic          cfg_burst,
    input  logic          cfg_single,
    input  logic          ext_req,
    input  logic          periph_req,
    input  logic          unit_done,
    output logic          pending,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output chan_mode_t    mode,
    output logic          done
);
    logic     en;
    req_src_e rsel;
    logic     req_raw;
    logic [AW-1:0] step;

    assign step = AW'(unit_bytes(mode.size));

    always_comb begin
        case (rsel)
            RQ_PIN:    req_raw = ext_req;
            RQ_AUTO:   req_raw = 1'b1;
            RQ_PERIPH: req_raw = periph_req;
            default:   req_raw = 1'b0;
        endcase
    end

    assign pending = en && req_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            done <= 1'b0;
            src  <= '0;
            dst  <= '0;
            cnt  <= '0;
            mode <= '0;
            rsel <= RQ_PIN;
        end else if (start) begin
            src         <= cfg_src;
            dst         <= cfg_dst;
            cnt         <= cfg_count;
            mode.size   <= cfg_size;
            mode.burst  <= cfg_burst;
            mode.single <= cfg_single;
            rsel        <= req_src_e'(cfg_reqsel);
            en          <= (cfg_count != '0);
            done        <= (cfg_count == '0);
        end else if (unit_done && en) begin
            cnt <= cnt - CW'(1);
            src <= src + step;
            dst <= dst + step;
            if (cnt == CW'(1)) begin
                en   <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    assert_zero_count_R2: assert property (@(posedge clk) disable iff (rst)
        (start && cfg_count == '0) |=> (done && !pending));

    assert_last_unit_R4: assert property (@(posedge clk) disable iff (rst)
        (!start && unit_done && en && cnt == CW'(1)) |=> (done && !pending));

endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
    parameter int NCH = 2,
    parameter int IW  = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pending,
    output logic [IW-1:0]  pick,
    output logic           any
);
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pending[i]) pick = IW'(i);
        end
    end

    assign any = |pending;

    assert_prio_R1: assert property (@(posedge clk) disable iff (rst)
        pending[0] |-> (pick == '0));

endmodule

// File: rtl/dma2_xfer.sv
module dma2_xfer
    import dma2_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int NCH = 2,
    parameter int IW  = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           any,
    input  logic [IW-1:0]  pick,
    input  logic [AW-1:0]  cur_src,
    input  logic [AW-1:0]  cur_dst,
    input  chan_mode_t     cur_mode,
    input  logic           cur_last,
    output logic [IW-1:0]  cur,
    output logic [NCH-1:0] unit_done,
    output logic [NCH-1:0] ack,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           m_valid,
    output logic           m_write,
    output logic [AW-1:0]  m_addr,
    output logic [1:0]     m_size,
    output logic [DW-1:0]  m_wdata,
    input  logic           m_ready,
    input  logic [DW-1:0]  m_rdata
);
    xfer_state_e st;
    logic [DW-1:0] hold;
    logic single_end, finish;

    assign single_end = (st == ST_READ) && m_ready && cur_mode.single;
    assign finish     = single_end || ((st == ST_WRITE) && m_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cur  <= '0;
            hold <= '0;
        end else begin
            case (st)
                ST_IDLE: if (any) st <= ST_WAIT;
                ST_WAIT: begin
                    if (!any) st <= ST_IDLE;
                    else if (bus_gnt) begin
                        cur <= pick;
                        st  <= ST_READ;
                    end
                end
                ST_READ: if (m_ready) begin
                    hold <= m_rdata;
                    if (!cur_mode.single) st <= ST_WRITE;
                end
                default: ;
            endcase
            if (finish) st <= (cur_mode.burst && !cur_last) ? ST_READ : ST_IDLE;
        end
    end

    always_comb begin
        unit_done = '0;
        ack       = '0;
        if (finish)     unit_done[cur] = 1'b1;
        if (single_end) ack[cur]       = 1'b1;
    end

    assign bus_req = (st != ST_IDLE);
    assign m_valid = (st == ST_READ) || (st == ST_WRITE);
    assign m_write = (st == ST_WRITE);
    assign m_addr  = (st == ST_WRITE) ? cur_dst : cur_src;
    assign m_size  = cur_mode.size;
    assign m_wdata = hold;

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (finish && (!cur_mode.burst || cur_last)) |=> !bus_req);

    assert_burst_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (finish && cur_mode.burst && !cur_last) |=> (bus_req && m_valid && $stable(cur)));

    assert_rd_before_wr_R7: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_write && !$past(m_valid && m_write))
            |-> $past(m_valid && !m_write && m_ready));

    assert_gnt_first_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(m_valid) |-> $past(bus_gnt));

endmodule

// File: rtl/dma2_ctrl.sv
module dma2_ctrl
    import dma2_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCH-1:0]          start,
    input  logic [NCH-1:0][AW-1:0]  cfg_src,
    input  logic [NCH-1:0][AW-1:0]  cfg_dst,
    input  logic [NCH-1:0][CW-1:0]  cfg_count,
    input  logic [NCH-1:0][1:0]     cfg_size,
    input  logic [NCH-1:0][1:0]     cfg_reqsel,
    input  logic [NCH-1:0]          cfg_burst,
    input  logic [NCH-1:0]          cfg_single,
    input  logic [NCH-1:0]          ext_req,
    input  logic [NCH-1:0]          periph_req,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output logic                    m_valid,
    output logic                    m_write,
    output logic [AW-1:0]           m_addr,
    output logic [1:0]              m_size,
    output logic [DW-1:0]           m_wdata,
    input  logic                    m_ready,
    input  logic [DW-1:0]           m_rdata,
    output logic [NCH-1:0]          ack,
    output logic [NCH-1:0]          done
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0]         pending, unit_done;
    logic [NCH-1:0][AW-1:0] src_q, dst_q;
    logic [NCH-1:0][CW-1:0] cnt_q;
    chan_mode_t             mode_q [NCH];
    logic [IW-1:0]          pick, cur;
    logic                   any;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dma2_chan #(.AW(AW), .CW(CW)) i_chan (
            .clk        (clk),
            .rst        (rst),
            .start      (start[c]),
            .cfg_src    (cfg_src[c]),
            .cfg_dst    (cfg_dst[c]),
            .cfg_count  (cfg_count[c]),
            .cfg_size   (cfg_size[c]),
            .cfg_reqsel (cfg_reqsel[c]),
            .cfg_burst  (cfg_burst[c]),
            .cfg_single (cfg_single[c]),
            .ext_req    (ext_req[c]),
            .periph_req (periph_req[c]),
            .unit_done  (unit_done[c]),
            .pending    (pending[c]),
            .src        (src_q[c]),
            .dst        (dst_q[c]),
            .cnt        (cnt_q[c]),
            .mode       (mode_q[c]),
            .done       (done[c])
        );
    end

    dma2_arb #(.NCH(NCH), .IW(IW)) i_arb (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .pick    (pick),
        .any     (any)
    );

    dma2_xfer #(.AW(AW), .DW(DW), .NCH(NCH), .IW(IW)) i_xfer (
        .clk       (clk),
        .rst       (rst),
        .any       (any),
        .pick      (pick),
        .cur_src   (src_q[cur]),
        .cur_dst   (dst_q[cur]),
        .cur_mode  (mode_q[cur]),
        .cur_last  (cnt_q[cur] == CW'(1)),
        .cur       (cur),
        .unit_done (unit_done),
        .ack       (ack),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .m_valid   (m_valid),
        .m_write   (m_write),
        .m_addr    (m_addr),
        .m_size    (m_size),
        .m_wdata   (m_wdata),
        .m_ready   (m_ready),
        .m_rdata   (m_rdata)
    );

endmodule

// File: tb/test_dma2_ctrl.sv
`timescale 1ns/1ps
module test_dma2_ctrl;
    localparam int NCH = 2, AW = 32, DW = 32, CW = 16;
    localparam int LOG = 256;

    typedef struct packed {
        logic        ch;
        logic        wt;
        logic        burst;
        logic        single;
        logic [1:0]  sz;
        logic [15:0] cnt;
        logic [31:0] src;
        logic [31:0] dst;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'd3, 32'h0000_1000, 32'h0000_2000},
        '{1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 16'd4, 32'h0000_3000, 32'h0000_4000},
        '{1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 16'd5, 32'h0000_5000, 32'h0000_6000},
        '{1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 16'd3, 32'h0000_7000, 32'h0000_0000},
        '{1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 16'd2, 32'h0000_8000, 32'h0000_0000},
        '{1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 16'd1, 32'h0000_9000, 32'h0000_A000}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic [NCH-1:0]         start = '0;
    logic [NCH-1:0][AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic [NCH-1:0][CW-1:0] cfg_count = '0;
    logic [NCH-1:0][1:0]    cfg_size = '0, cfg_reqsel = '0;
    logic [NCH-1:0]         cfg_burst = '0, cfg_single = '0;
    logic [NCH-1:0]         ext_req = '0, periph_req = '0;
    logic bus_req, bus_gnt, m_valid, m_write, m_ready;
    logic [AW-1:0] m_addr;
    logic [1:0]    m_size;
    logic [DW-1:0] m_wdata, m_rdata;
    logic [NCH-1:0] ack, done;

    logic gnt_q = 1'b0, hold_gnt = 1'b0, wt_mode = 1'b0, phase = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0]};
    endfunction

    always_ff @(posedge clk) begin
        gnt_q <= rst ? 1'b0 : (bus_req && !hold_gnt);
        phase <= ~phase;
    end
    assign bus_gnt = gnt_q;
    assign m_ready = wt_mode ? phase : 1'b1;
    assign m_rdata = pat(m_addr);

    dma2_ctrl #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) i_dma2_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
        .cfg_size(cfg_size), .cfg_reqsel(cfg_reqsel),
        .cfg_burst(cfg_burst), .cfg_single(cfg_single),
        .ext_req(ext_req), .periph_req(periph_req),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
        .m_size(m_size), .m_wdata(m_wdata), .m_ready(m_ready),
        .m_rdata(m_rdata), .ack(ack), .done(done)
    );

    // access logs, sampled at the falling edge
    logic [31:0] wr_a [LOG];
    logic [31:0] wr_d [LOG];
    logic [31:0] rd_a [LOG];
    int nwr = 0, nrd = 0, nack = 0, nreq = 0;
    int n_chk = 0, n_fail = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (bus_req) nreq++;
            if (|ack) nack++;
            if (m_valid && m_ready) begin
                if (m_write) begin
                    if (nwr < LOG) begin wr_a[nwr] = m_addr; wr_d[nwr] = m_wdata; end
                    nwr++;
                end else begin
                    if (nrd < LOG) rd_a[nrd] = m_addr;
                    nrd++;
                end
            end
        end
    end

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        nwr = 0; nrd = 0; nack = 0; nreq = 0;
    endtask

    task automatic set_cfg(input int ch, input logic [31:0] s, input logic [31:0] d,
                           input logic [15:0] n, input logic [1:0] sz, input logic [1:0] rs,
                           input logic b, input logic sg);
        cfg_src[ch] = s; cfg_dst[ch] = d; cfg_count[ch] = n;
        cfg_size[ch] = sz; cfg_reqsel[ch] = rs;
        cfg_burst[ch] = b; cfg_single[ch] = sg;
    endtask

    task automatic pulse(input logic [NCH-1:0] which);
        start = which;
        @(negedge clk);
        start = '0;
    endtask

    task automatic wait_done(input logic [NCH-1:0] which);
        for (int k = 0; k < 3000; k++) begin
            if ((done & which) == which) break;
            @(negedge clk);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] bytes_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        settle(3);
        // R11: reset state
        check(!bus_req && !m_valid && ack == '0 && done == '0, "R11", "reset outputs",
              {28'd0, bus_req, m_valid, done}, 32'd0);
        @(negedge clk); rst = 1'b0;
        settle(2);

        // table walk: each vector on an auto-requested channel
        for (int v = 0; v < 6; v++) begin
            vec_t t;
            logic [31:0] b, bad;
            int nb;
            t = VECS[v];
            b = bytes_of(t.sz);
            wt_mode = t.wt;
            clear_logs();
            set_cfg(int'(t.ch), t.src, t.dst, t.cnt, t.sz, 2'd1, t.burst, t.single);
            pulse(t.ch ? 2'b10 : 2'b01);
            wait_done(t.ch ? 2'b10 : 2'b01);
            settle(4);
            check(done[t.ch] == 1'b1, "R4", "done after last unit", {31'd0, done[t.ch]}, 32'd1);
            check(nrd == int'(t.cnt), "R3", "read unit count", nrd, {16'd0, t.cnt});
            bad = 0;
            for (int i = 0; i < int'(t.cnt); i++)
                if (rd_a[i] != t.src + b * i) bad++;
            check(bad == 0, "R3", "read addresses step by width", bad, 0);
            if (t.single) begin
                check(nwr == 0, "R8", "no write in single mode", nwr, 0);
                check(nack == int'(t.cnt), "R8", "ack per unit", nack, {16'd0, t.cnt});
            end else begin
                check(nwr == int'(t.cnt), "R7", "write unit count", nwr, {16'd0, t.cnt});
                bad = 0;
                for (int i = 0; i < int'(t.cnt); i++)
                    if (wr_a[i] != t.dst + b * i || wr_d[i] != pat(t.src + b * i)) bad++;
                check(bad == 0, (t.wt ? "R10" : "R7"), "write address and data", bad, 0);
            end
            nb = nrd + nwr;
            settle(20);
            check(nrd + nwr == nb && !bus_req, "R4", "no access after done", nrd + nwr, nb);
        end
        wt_mode = 1'b0;

        // R2: zero count
        clear_logs();
        set_cfg(0, 32'h100, 32'h200, 16'd0, 2'd2, 2'd1, 1'b0, 1'b0);
        pulse(2'b01);
        check(done[0] == 1'b1, "R2", "zero count done", {31'd0, done[0]}, 32'd1);
        settle(10);
        check(nrd == 0 && nreq == 0, "R2", "zero count no access", nrd + nreq, 0);

        // R9: pin request ignored while low, then served
        clear_logs();
        set_cfg(0, 32'h1100, 32'h1200, 16'd2, 2'd2, 2'd0, 1'b0, 1'b0);
        pulse(2'b01);
        settle(20);
        check(nreq == 0 && done[0] == 1'b0, "R9", "pin low: no bus request", nreq, 0);
        ext_req[0] = 1'b1;
        wait_done(2'b01); settle(2);
        ext_req[0] = 1'b0;
        check(nwr == 2 && done[0], "R9", "pin high: served", nwr, 2);

        // R9: peripheral request on channel 1
        clear_logs();
        set_cfg(1, 32'h1300, 32'h1400, 16'd2, 2'd1, 2'd2, 1'b1, 1'b0);
        pulse(2'b10);
        ext_req[1] = 1'b1;
        settle(20);
        check(nreq == 0 && done[1] == 1'b0, "R9", "periph low: no request", nreq, 0);
        ext_req[1] = 1'b0;
        periph_req[1] = 1'b1;
        wait_done(2'b10); settle(2);
        periph_req[1] = 1'b0;
        check(nwr == 2 && done[1], "R9", "periph high: served", nwr, 2);

        // R1: both started together, channel 0 first
        clear_logs();
        set_cfg(0, 32'h2100, 32'h2200, 16'd2, 2'd2, 2'd1, 1'b0, 1'b0);
        set_cfg(1, 32'h2300, 32'h2400, 16'd2, 2'd2, 2'd1, 1'b0, 1'b0);
        pulse(2'b11);
        wait_done(2'b11); settle(2);
        check(nwr == 4 && wr_a[0] == 32'h2200 && wr_a[1] == 32'h2204, "R1",
              "channel 0 served first", wr_a[0], 32'h2200);

        // R6: burst on channel 1 is not preempted
        clear_logs();
        set_cfg(1, 32'h3100, 32'h3200, 16'd4, 2'd2, 2'd1, 1'b1, 1'b0);
        pulse(2'b10);
        for (int k = 0; k < 200 && nwr == 0; k++) @(negedge clk);
        set_cfg(0, 32'h3300, 32'h3400, 16'd2, 2'd2, 2'd1, 1'b0, 1'b0);
        pulse(2'b01);
        wait_done(2'b11); settle(2);
        check(nwr == 6 && wr_a[3] == 32'h320C && wr_a[4] == 32'h3400, "R6",
              "burst kept the bus", wr_a[4], 32'h3400);

        // R5: cycle-steal on channel 1 yields to channel 0 between units
        clear_logs();
        set_cfg(1, 32'h4100, 32'h4200, 16'd4, 2'd2, 2'd1, 1'b0, 1'b0);
        pulse(2'b10);
        for (int k = 0; k < 200 && nwr == 0; k++) @(negedge clk);
        set_cfg(0, 32'h4300, 32'h4400, 16'd2, 2'd2, 2'd1, 1'b0, 1'b0);
        pulse(2'b01);
        wait_done(2'b11); settle(2);
        check(nwr == 6 && wr_a[1] == 32'h4400 && wr_a[5] == 32'h420C, "R5",
              "channel 0 interleaved", wr_a[1], 32'h4400);

        // R10: no access while grant withheld
        clear_logs();
        hold_gnt = 1'b1;
        set_cfg(0, 32'h5100, 32'h5200, 16'd1, 2'd2, 2'd1, 1'b0, 1'b0);
        pulse(2'b01);
        settle(15);
        check(nrd == 0 && bus_req, "R10", "no access without grant", nrd, 0);
        hold_gnt = 1'b0;
        wait_done(2'b01); settle(2);
        check(nwr == 1 && wr_d[0] == pat(32'h5100), "R10", "access after grant",
              wr_d[0], pat(32'h5100));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule